// File: doc/BRIEF.md
# Page Write Collector and Self-Timed Programmer

This block sits behind a serial memory command decoder. When the decoder recognises a data-array write or a status-byte write, it announces the start address and the kind of write. It then forwards each received data byte with a strobe. The block keeps the bytes in a one-page staging buffer. The write position advances only inside the page, so a long burst wraps back to the page start and replaces bytes it stored earlier.

When the decoder reports that chip select has risen, it also passes the number of bits clocked in since select. The block then decides whether the sequence ended cleanly. A clean end starts a self-timed programming cycle whose length is a cycle-count parameter. During that cycle the block raises its busy flag and plays the staged bytes out on the array write port in ascending in-page order. For a status write it drives a single status-byte write strobe instead. In the final busy cycle it pulses a signal that clears the write-enable latch. Every request that arrives while the block is busy is discarded.

Bytes whose address is at or above a protection limit are not written to the array. The limit is sampled when the write is accepted. Protected bytes are simply skipped, and the other bytes of the same page are still written.

Top module: `page_write_engine`

## Requirements
- R1: Out of reset `wip`, `wel_clr`, `arr_we` and `sr_we` are all 0 and no write is pending.
- R2: Array data bytes are staged at the in-page offset of `start_addr` (its low log2(PAGE_BYTES) bits, 5 by default). The offset then increments modulo PAGE_BYTES while the page number (upper address bits) stays fixed. A byte that lands on an already filled offset replaces the earlier one.
- R3: An array write is accepted only if all of these hold when `cs_rise` arrives: `bit_count` is a multiple of 8 (low 3 bits zero), `bit_count` is at least 32, `wel` is 1, and at least one data byte was received. Any other rise cancels the sequence, and `wip` stays 0.
- R4: A status write (`start_kind` = 1) is accepted only if `bit_count` equals exactly 16, `wel` is 1 and `sr_lock` is 0. When accepted, `sr_we` pulses once, in the first busy cycle, carrying the received byte on `sr_wdata`.
- R5: After an accepted `cs_rise`, `wip` is 1 from the next cycle on, for exactly PROG_CYCLES cycles. `wel_clr` is a single-cycle pulse in the last of those cycles.
- R6: While `wip` is 1, `start_valid`, `byte_valid` and `cs_rise` have no effect. The cycle length and its writes are unchanged, and no new sequence is open when it ends. A byte or a chip-select rise in the idle state, with no preceding start, is likewise ignored.
- R7: Array writes occur only in the first PAGE_BYTES busy cycles. Offset k of the page is offered in busy cycle k (counting from 0), so writes come out in ascending offset order, one per staged offset. `arr_addr` is the page number joined to the offset.
- R8: A staged byte whose address is greater than or equal to `prot_limit`, as sampled at the accepting `cs_rise`, is not written. Staged bytes below the limit are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Opens a write sequence |
| start_kind | input | 1 | 0 = array write, 1 = status-byte write |
| start_addr | input | AW | First array address of the sequence |
| byte_valid | input | 1 | One data byte is present |
| byte_data | input | 8 | Data byte |
| cs_rise | input | 1 | Chip select has risen (end of sequence) |
| bit_count | input | CNT_W | Bits clocked in since select, at the rise |
| wel | input | 1 | Write-enable latch state |
| sr_lock | input | 1 | Status byte is write-locked |
| prot_limit | input | AW+1 | Lowest protected address (2^AW = none) |
| arr_we | output | 1 | Array byte write strobe |
| arr_addr | output | AW | Array write address |
| arr_wdata | output | 8 | Array write data |
| sr_we | output | 1 | Status-byte write strobe |
| sr_wdata | output | 8 | Status-byte value |
| wip | output | 1 | Programming cycle in progress |
| wel_clr | output | 1 | End-of-cycle pulse that clears the enable latch |

## Verification
The assertions check on every cycle that array and status strobes appear only while busy and that status writes fall in the first busy cycle. They also check that array addresses climb within one cycle, that nothing at or above the sampled limit is written, that the busy window lasts exactly the programmed length and ends on the clear pulse, and that every launch follows a chip-select rise on a byte boundary with the latch set. Only the bench scenarios can show the actual content of the page after wrap-around, the acceptance and rejection of particular bit counts and permission states, and the fact that requests issued during the busy window leave no trace. The bench checks these against a cycle-level model and against a record of what reached the array.

// File: rtl/pw_pkg.sv
package pw_pkg;

    localparam int BYTE_BITS      = 8;
    localparam int SR_COMMIT_BITS = 16;
    localparam int ARRAY_MIN_BITS = 32;

    typedef enum logic [1:0] {
        PW_IDLE = 2'd0,
        PW_FILL = 2'd1,
        PW_PROG = 2'd2
    } pw_state_e;

    typedef enum logic {
        PW_ARRAY  = 1'b0,
        PW_STATUS = 1'b1
    } pw_kind_e;

    typedef struct packed {
        logic                 full;
        logic [BYTE_BITS-1:0] data;
    } pw_slot_t;

    function automatic logic on_byte_edge(input logic [2:0] low3);
        return low3 == 3'd0;
    endfunction

endpackage

// File: rtl/pw_slot_buffer.sv
module pw_slot_buffer
    import pw_pkg::*;
#(
    parameter int PAGE_BYTES = 32,
    localparam int PW = $clog2(PAGE_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_en,
    input  logic [PW-1:0]        load_off,
    input  logic                 wr_en,
    input  logic [BYTE_BITS-1:0] wr_data,
    input  logic [PW-1:0]        rd_idx,
    output pw_slot_t             rd_slot,
    output logic                 any_byte
);

    logic [PW-1:0]   ptr;
    pw_slot_t        slots [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] full_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (load_en) begin
            ptr <= load_off;
        end else if (wr_en) begin
            ptr <= ptr + 1'b1;
        end
    end

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || load_en) begin
                slots[i] <= '0;
            end else if (wr_en && ptr == PW'(i)) begin
                slots[i].full <= 1'b1;
                slots[i].data <= wr_data;
            end
        end
        assign full_vec[i] = slots[i].full;
    end

    assign rd_slot  = slots[rd_idx];
    assign any_byte = |full_vec;

endmodule

// File: rtl/pw_commit_gate.sv
module pw_commit_gate
    import pw_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  pw_kind_e         kind,
    input  logic [CNT_W-1:0] bit_count,
    input  logic             wel,
    input  logic             sr_lock,
    input  logic             any_byte,
    output logic             accept
);

    logic array_ok;
    logic status_ok;

    always_comb begin
        array_ok  = on_byte_edge(bit_count[2:0]) &&
                    (bit_count >= CNT_W'(ARRAY_MIN_BITS));
        status_ok = (bit_count == CNT_W'(SR_COMMIT_BITS)) && !sr_lock;
        accept    = wel && any_byte &&
                    ((kind == PW_STATUS) ? status_ok : array_ok);
    end

endmodule

// File: rtl/pw_prog_sequencer.sv
module pw_prog_sequencer #(
    parameter int PROG_CYCLES = 500000,
    parameter int PAGE_BYTES  = 32,
    localparam int PW     = $clog2(PAGE_BYTES),
    localparam int CW     = $clog2(PROG_CYCLES + 1),
    localparam int SCAN_N = (PROG_CYCLES < PAGE_BYTES) ? PROG_CYCLES : PAGE_BYTES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    output logic          busy,
    output logic          first,
    output logic          last,
    output logic          scan_on,
    output logic [PW-1:0] scan_idx
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == CW'(PROG_CYCLES - 1)) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (launch) begin
            busy <= 1'b1;
            cnt  <= '0;
        end
    end

    assign first    = busy && (cnt == '0);
    assign last     = busy && (cnt == CW'(PROG_CYCLES - 1));
    assign scan_on  = busy && (cnt < CW'(SCAN_N));
    assign scan_idx = cnt[PW-1:0];

endmodule

// File: rtl/page_write_engine.sv
module page_write_engine
    import pw_pkg::*;
#(
    parameter int AW          = 13,
    parameter int PAGE_BYTES  = 32,
    parameter int CNT_W       = 16,
    parameter int PROG_CYCLES = 500000,
    localparam int PW = $clog2(PAGE_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_valid,
    input  logic                 start_kind,
    input  logic [AW-1:0]        start_addr,
    input  logic                 byte_valid,
    input  logic [BYTE_BITS-1:0] byte_data,
    input  logic                 cs_rise,
    input  logic [CNT_W-1:0]     bit_count,
    input  logic                 wel,
    input  logic                 sr_lock,
    input  logic [AW:0]          prot_limit,
    output logic                 arr_we,
    output logic [AW-1:0]        arr_addr,
    output logic [BYTE_BITS-1:0] arr_wdata,
    output logic                 sr_we,
    output logic [BYTE_BITS-1:0] sr_wdata,
    output logic                 wip,
    output logic                 wel_clr
);

    pw_state_e            state;
    pw_kind_e             kind_q;
    logic [AW-PW-1:0]     page_q;
    logic [AW:0]          lim_q;
    logic [BYTE_BITS-1:0] sr_q;

    logic     buf_load, buf_wr, any_byte, accept, launch;
    logic     busy, first, last, scan_on;
    logic [PW-1:0] scan_idx;
    pw_slot_t rd_slot;

    assign buf_load = (state != PW_PROG) && start_valid;
    assign buf_wr   = (state == PW_FILL) && !start_valid && !cs_rise && byte_valid;
    assign launch   = (state == PW_FILL) && !start_valid && cs_rise && accept;

    pw_slot_buffer #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .load_en  (buf_load),
        .load_off (start_addr[PW-1:0]),
        .wr_en    (buf_wr),
        .wr_data  (byte_data),
        .rd_idx   (scan_idx),
        .rd_slot  (rd_slot),
        .any_byte (any_byte)
    );

    pw_commit_gate #(.CNT_W(CNT_W)) u_gate (
        .kind      (kind_q),
        .bit_count (bit_count),
        .wel       (wel),
        .sr_lock   (sr_lock),
        .any_byte  (any_byte),
        .accept    (accept)
    );

    pw_prog_sequencer #(.PROG_CYCLES(PROG_CYCLES), .PAGE_BYTES(PAGE_BYTES)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .launch   (launch),
        .busy     (busy),
        .first    (first),
        .last     (last),
        .scan_on  (scan_on),
        .scan_idx (scan_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= PW_IDLE;
            kind_q <= PW_ARRAY;
            page_q <= '0;
            lim_q  <= '0;
            sr_q   <= '0;
        end else begin
            case (state)
                PW_IDLE: begin
                    if (start_valid) begin
                        state  <= PW_FILL;
                        kind_q <= pw_kind_e'(start_kind);
                        page_q <= start_addr[AW-1:PW];
                    end
                end
                PW_FILL: begin
                    if (start_valid) begin
                        kind_q <= pw_kind_e'(start_kind);
                        page_q <= start_addr[AW-1:PW];
                    end else if (cs_rise) begin
                        if (accept) begin
                            state <= PW_PROG;
                            lim_q <= prot_limit;
                        end else begin
                            state <= PW_IDLE;
                        end
                    end else if (byte_valid) begin
                        sr_q <= byte_data;
                    end
                end
                PW_PROG: begin
                    if (last) begin
                        state <= PW_IDLE;
                    end
                end
                default: state <= PW_IDLE;
            endcase
        end
    end

    always_comb begin
        arr_addr  = {page_q, scan_idx};
        arr_wdata = rd_slot.data;
        arr_we    = scan_on && (kind_q == PW_ARRAY) && rd_slot.full &&
                    ({1'b0, arr_addr} < lim_q);
        sr_we     = first && (kind_q == PW_STATUS);
        sr_wdata  = sr_q;
        wip       = busy;
        wel_clr   = last;
    end

endmodule

// File: rtl/page_write_engine_chk.sv
module page_write_engine_chk #(
    parameter int AW          = 13,
    parameter int PAGE_BYTES  = 32,
    parameter int CNT_W       = 16,
    parameter int PROG_CYCLES = 500000,
    localparam int PW = $clog2(PAGE_BYTES)
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_rise,
    input logic [CNT_W-1:0] bit_count,
    input logic             wel,
    input logic [AW:0]      prot_limit,
    input logic             arr_we,
    input logic [AW-1:0]    arr_addr,
    input logic             sr_we,
    input logic             wip,
    input logic             wel_clr
);

    int          run;
    logic [AW:0] lim_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            run      <= 0;
            lim_seen <= '0;
        end else begin
            run <= wip ? run + 1 : 0;
            if (cs_rise && !wip) lim_seen <= prot_limit;
        end
    end

    // R1 / R7: no strobe outside the busy window
    a_r7_we_only_busy: assert property (@(posedge clk) disable iff (rst)
        (arr_we || sr_we || wel_clr) |-> wip);

    // R4: status strobe in the first busy cycle
    a_r4_sr_first: assert property (@(posedge clk) disable iff (rst)
        sr_we |-> (wip && !$past(wip)));

    // R5: clear pulse in the last busy cycle
    a_r5_done_last: assert property (@(posedge clk) disable iff (rst)
        wel_clr |-> (run == PROG_CYCLES - 1));

    // R5: busy window length
    a_r5_busy_length: assert property (@(posedge clk) disable iff (rst)
        (!wip && $past(wip)) |-> (run == PROG_CYCLES && $past(wel_clr)));

    // R3: launch only after a byte-aligned rise with the latch set
    a_r3_launch_cause: assert property (@(posedge clk) disable iff (rst)
        (wip && !$past(wip)) |->
        ($past(cs_rise) && $past(wel) && ($past(bit_count[2:0]) == 3'd0)));

    // R7: ascending offsets
    a_r7_ascending: assert property (@(posedge clk) disable iff (rst)
        (arr_we && $past(arr_we)) |-> (arr_addr[PW-1:0] > $past(arr_addr[PW-1:0])));

    // R8: nothing at or above the sampled limit
    a_r8_below_limit: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> ({1'b0, arr_addr} < lim_seen));

endmodule

bind page_write_engine page_write_engine_chk #(
    .AW(AW), .PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_rise    (cs_rise),
    .bit_count  (bit_count),
    .wel        (wel),
    .prot_limit (prot_limit),
    .arr_we     (arr_we),
    .arr_addr   (arr_addr),
    .sr_we      (sr_we),
    .wip        (wip),
    .wel_clr    (wel_clr)
);

// File: tb/page_write_engine_tb.sv
module page_write_engine_tb;

    localparam int AW    = 13;
    localparam int PG    = 32;
    localparam int CW    = 16;
    localparam int P     = 40;
    localparam int NONE  = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_valid = 0, start_kind = 0, byte_valid = 0, cs_rise = 0;
    logic wel = 0, sr_lock = 0;
    logic [AW-1:0] start_addr = '0;
    logic [7:0]    byte_data = '0;
    logic [CW-1:0] bit_count = '0;
    logic [AW:0]   prot_limit = AW'(0) + (AW+1)'(NONE);
    logic arr_we, sr_we, wip, wel_clr;
    logic [AW-1:0] arr_addr;
    logic [7:0]    arr_wdata, sr_wdata;

    page_write_engine #(.AW(AW), .PAGE_BYTES(PG), .CNT_W(CW), .PROG_CYCLES(P)) u_dut (
        .clk(clk), .rst(rst), .start_valid(start_valid), .start_kind(start_kind),
        .start_addr(start_addr), .byte_valid(byte_valid), .byte_data(byte_data),
        .cs_rise(cs_rise), .bit_count(bit_count), .wel(wel), .sr_lock(sr_lock),
        .prot_limit(prot_limit), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .sr_we(sr_we), .sr_wdata(sr_wdata),
        .wip(wip), .wel_clr(wel_clr)
    );

    always #10 clk = ~clk;

    int    n_cmp = 0, n_bad = 0;
    string cur_req = "R1";
    int    mem [0:(1<<AW)-1];
    int    sr_hits = 0, sr_last = -1, done_hits = 0;
    bit    finished = 0;

    // behavioural reference
    bit m_busy = 0, m_fill = 0, m_have = 0;
    int m_t = 0, m_kind = 0, m_base = 0, m_off = 0, m_lim = 0, m_sr = 0;
    int m_pg [PG];

    always @(posedge clk) begin
        bit ok;
        if (rst) begin
            m_busy = 0; m_fill = 0;
        end else if (m_busy) begin
            m_t++;
            if (m_t == P) m_busy = 0;
        end else if (start_valid) begin
            m_fill = 1; m_kind = start_kind; m_base = int'(start_addr) / PG;
            m_off = int'(start_addr) % PG; m_have = 0;
            for (int i = 0; i < PG; i++) m_pg[i] = -1;
        end else if (m_fill) begin
            if (cs_rise) begin
                m_fill = 0;
                if (m_kind == 1) ok = (int'(bit_count) == 16) && !sr_lock;
                else             ok = (int'(bit_count) % 8 == 0) && (int'(bit_count) >= 32);
                if (ok && wel && m_have) begin
                    m_busy = 1; m_t = 0; m_lim = int'(prot_limit);
                end
            end else if (byte_valid) begin
                m_pg[m_off] = int'(byte_data); m_off = (m_off + 1) % PG;
                m_have = 1; m_sr = int'(byte_data);
            end
        end
    end

    task automatic check(input bit good, input string req, input int act, input int exp);
        n_cmp++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            bit e_we, e_sr, e_done;
            int e_addr, e_data;
            e_done = m_busy && m_t == P - 1;
            e_sr   = m_busy && m_kind == 1 && m_t == 0;
            e_addr = m_base * PG + m_t;
            e_data = (m_t < PG) ? m_pg[m_t] : -1;
            e_we   = m_busy && m_kind == 0 && m_t < PG && e_data >= 0 && e_addr < m_lim;
            check(wip == m_busy && wel_clr == e_done && sr_we == e_sr && arr_we == e_we
                  && (!e_we || (int'(arr_addr) == e_addr && int'(arr_wdata) == e_data))
                  && (!e_sr || int'(sr_wdata) == m_sr),
                  {cur_req, " cycle model"},
                  {28'd0, wip, wel_clr, sr_we, arr_we}, {28'd0, m_busy, e_done, e_sr, e_we});
            if (arr_we) mem[arr_addr] = int'(arr_wdata);
            if (sr_we) begin sr_hits++; sr_last = int'(sr_wdata); end
            if (wel_clr) done_hits++;
        end
    end

    task automatic do_start(input bit k, input int a);
        start_valid = 1; start_kind = k; start_addr = AW'(a);
        @(negedge clk); start_valid = 0;
    endtask

    task automatic do_byte(input int d);
        byte_valid = 1; byte_data = 8'(d);
        @(negedge clk); byte_valid = 0;
    endtask

    task automatic do_rise(input int bc);
        cs_rise = 1; bit_count = CW'(bc);
        @(negedge clk); cs_rise = 0;
    endtask

    task automatic settle();
        repeat (P + 4) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not end actual=0 expected=1");
        finish_run();
    end

    initial begin
        int wlen;
        for (int i = 0; i < (1 << AW); i++) mem[i] = -1;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: idle after reset
        check(!wip && !arr_we && !sr_we && !wel_clr, "R1 reset state",
              {wip, arr_we, sr_we, wel_clr}, 0);

        // R2/R5/R7: four bytes from offset 3
        cur_req = "R2 R5 R7";
        wel = 1;
        do_start(0, 'h123);
        for (int k = 0; k < 4; k++) do_byte('hA0 + k);
        do_rise(24 + 32);
        wlen = 0;
        while (wip) begin wlen++; @(negedge clk); end
        check(wlen == P, "R5 busy length", wlen, P);
        check(done_hits == 1, "R5 single clear pulse", done_hits, 1);
        for (int k = 0; k < 4; k++)
            check(mem['h123 + k] == 'hA0 + k, "R2 staged byte", mem['h123 + k], 'hA0 + k);
        check(mem['h122] == -1 && mem['h127] == -1, "R7 neighbours untouched", mem['h127], -1);
        settle();

        // R2: wrap with overwrite
        cur_req = "R2 wrap";
        do_start(0, 'h07E);
        for (int k = 0; k < 34; k++) do_byte('h40 + k);
        do_rise(24 + 8 * 34);
        settle();
        check(mem['h07E] == 'h60, "R2 wrap overwrite", mem['h07E], 'h60);
        check(mem['h07F] == 'h61, "R2 wrap overwrite", mem['h07F], 'h61);
        check(mem['h060] == 'h42, "R2 wrap to page start", mem['h060], 'h42);
        check(mem['h07D] == 'h5F, "R2 wrap last offset", mem['h07D], 'h5F);
        check(mem['h080] == -1, "R2 page boundary held", mem['h080], -1);

        // R3: rejected endings
        cur_req = "R3";
        do_start(0, 'h200); do_byte('h11); do_rise(33);
        settle();
        check(mem['h200] == -1, "R3 misaligned rise", mem['h200], -1);
        wel = 0;
        do_start(0, 'h210); do_byte('h12); do_rise(32);
        settle();
        check(mem['h210] == -1, "R3 latch clear", mem['h210], -1);
        wel = 1;
        do_start(0, 'h220); do_rise(24);
        @(negedge clk);
        check(!wip, "R3 no data byte", wip, 0);
        do_start(0, 'h230); do_byte('h13); do_rise(24);
        @(negedge clk);
        check(!wip, "R3 below 32 bits", wip, 0);
        settle();

        // R4: status writes
        cur_req = "R4";
        do_start(1, 0); do_byte('h8C); do_rise(16);
        settle();
        check(sr_hits == 1 && sr_last == 'h8C, "R4 status commit", sr_last, 'h8C);
        do_start(1, 0); do_byte('h33); do_rise(17);
        settle();
        check(sr_hits == 1, "R4 late rise rejected", sr_hits, 1);
        sr_lock = 1;
        do_start(1, 0); do_byte('h44); do_rise(16);
        settle();
        check(sr_hits == 1, "R4 locked rejected", sr_hits, 1);
        sr_lock = 0;

        // R8: protection limit inside the page
        cur_req = "R8";
        prot_limit = (AW+1)'('h130);
        do_start(0, 'h12E);
        for (int k = 0; k < 4; k++) do_byte('hC0 + k);
        do_rise(24 + 32);
        prot_limit = (AW+1)'(NONE);
        settle();
        check(mem['h12E] == 'hC0 && mem['h12F] == 'hC1, "R8 unprotected written",
              mem['h12F], 'hC1);
        check(mem['h130] == -1 && mem['h131] == -1, "R8 protected dropped",
              mem['h130], -1);

        // R6: requests during busy and idle strays
        cur_req = "R6";
        do_start(0, 'h300); do_byte('h55); do_rise(32);
        do_start(0, 'h340); do_byte('h22); do_rise(32);
        settle();
        check(mem['h300] == 'h55, "R6 running write intact", mem['h300], 'h55);
        check(mem['h340] == -1, "R6 busy request ignored", mem['h340], -1);
        do_byte('h77); do_rise(32);
        @(negedge clk);
        check(!wip, "R6 idle strays ignored", wip, 0);
        settle();
        check(done_hits == 5, "R5 clear pulse count", done_hits, 5);

        finish_run();
    end

endmodule